// File: doc/BRIEF.md
# Per-Lane I/O Delay Setting Store

This block keeps the delay settings for a bank of I/O lanes, 30 by default. Each lane has three 6-bit settings: one for the output and tri-state path, one for the input capture path, and one for the deskew tap. All three sit on a slow management clock that is independent of the data clocks. A write names a lane address, a 2-bit register selector and a 6-bit value, and is qualified by an active-high load strobe. A broadcast mode writes the same value into the selected setting of every lane in one cycle. The stored values of all lanes are presented continuously on flat output buses, which drive the delay lines.

Each lane also reports early-capture and late-capture conditions. These arrive as raw, unsynchronised per-lane inputs. The block brings them into the management clock domain with two flops, and then latches them until an active-low clear. The block also provides a readback of the addressed lane. One enable per lane marks which lane would drive a shared tri-state readback bus. A combined readback value and the combined early and late flags are also given, and they read zero when no lane matches the address.

Top module: `lane_delay_store`

## Requirements
- R1: While `rst` is high, every stored setting of every lane is cleared to zero and every latched flag is cleared.
- R2: With `singleLane` high, a write (`loadStb` high at a rising edge) changes only the addressed lane's setting chosen by `regSel`. The encodings are 2'b00 output/tri-state, 2'b01 input and 2'b10 deskew. Lane n's setting sits at bits [6n+5:6n] of its bus.
- R3: With `singleLane` low, a write stores `wrData` into the chosen setting of all lanes in the same edge.
- R4: No setting changes in a cycle where `loadStb` is low.
- R5: A write with `regSel` equal to 2'b11 changes no setting.
- R6: A write with a lane address of 30 or above changes no setting, in either the single-lane or the broadcast mode.
- R7: `rdValue` combinationally shows the addressed lane's setting chosen by `regSel`. It is zero when `regSel` is 2'b11 or when the address is 30 or above.
- R8: `laneOe` has bit n set exactly when `laneAddr` equals n, and it is all zero for addresses of 30 or above.
- R9: A raw early or late input held high sets that lane's latched flag on the third rising edge after it rises. The flag stays set after the raw input falls.
- R10: Holding `flagClrN` low at a rising edge clears the early and late flags of all lanes. `rdEarly` and `rdLate` show only the addressed lane's flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mgmtClk | input | 1 | Management clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| flagClrN | input | 1 | Active-low clear for all latched capture flags |
| loadStb | input | 1 | Active-high write strobe |
| singleLane | input | 1 | 1: write the addressed lane only; 0: write all lanes |
| laneAddr | input | 5 | Lane address for write and readback |
| regSel | input | 2 | Setting selector (00 output, 01 input, 10 deskew, 11 unused) |
| wrData | input | 6 | Value to store |
| earlyRaw | input | 30 | Raw early-capture indication per lane |
| lateRaw | input | 30 | Raw late-capture indication per lane |
| outDly | output | 180 | Output/tri-state delay of every lane, 6 bits each |
| inDly | output | 180 | Input delay of every lane, 6 bits each |
| dpaDly | output | 180 | Deskew delay of every lane, 6 bits each |
| laneOe | output | 30 | Per-lane readback drive enable |
| rdValue | output | 6 | Combined readback of the addressed lane |
| rdEarly | output | 1 | Latched early flag of the addressed lane |
| rdLate | output | 1 | Latched late flag of the addressed lane |

## Verification
Single-lane writes go to lane 5 and to the top lane, 29, with distinct non-zero values. The full buses are then compared against a model, which separates a correct lane decode from writes that leak into neighbours or slip by one field position. A broadcast write follows. It shows whether the mode bit is honoured and whether its polarity is right, because a swapped polarity would touch only one lane. Writes with the reserved selector, with addresses 30 and 31, and with the strobe low must leave the buses untouched. Readback of an out-of-range lane and of the reserved selector must give zero. A flag is raised on one lane and sampled one edge before and one edge after it is due, which pins the synchroniser depth. A neighbouring lane and the clear pulse then confirm isolation and clearing.

// File: rtl/lds_pkg.sv
package lds_pkg;
  typedef enum logic [1:0] {
    SEL_OUT = 2'b00,
    SEL_IN  = 2'b01,
    SEL_DPA = 2'b10,
    SEL_RSV = 2'b11
  } regSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrOut;
    logic wrIn;
    logic wrDpa;
    logic allLanes;
  } wrCmd_t;
endpackage

// File: rtl/lds_ctrl.sv
module lds_ctrl
  import lds_pkg::*;
#(
  parameter int LANES  = 30,
  parameter int ADDR_W = 5
) (
  input  logic              loadStb,
  input  logic              singleLane,
  input  logic [ADDR_W-1:0] laneAddr,
  input  logic [1:0]        regSel,
  output wrCmd_t            cmd
);
  logic addrOk;
  logic go;

  always_comb begin
    addrOk       = int'(laneAddr) < LANES;
    go           = loadStb && addrOk;
    cmd.wrOut    = go && (regSel == SEL_OUT);
    cmd.wrIn     = go && (regSel == SEL_IN);
    cmd.wrDpa    = go && (regSel == SEL_DPA);
    cmd.allLanes = !singleLane;
  end
endmodule

// File: rtl/lds_flags.sv
module lds_flags #(
  parameter int LANES = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clrN,
  input  logic [LANES-1:0] rawE,
  input  logic [LANES-1:0] rawL,
  output logic [LANES-1:0] holdE,
  output logic [LANES-1:0] holdL
);
  logic [LANES-1:0] metaE, metaL, syncE, syncL;

  always_ff @(posedge clk) begin
    if (rst) begin
      metaE <= '0;
      metaL <= '0;
      syncE <= '0;
      syncL <= '0;
      holdE <= '0;
      holdL <= '0;
    end else begin
      metaE <= rawE;
      metaL <= rawL;
      syncE <= metaE;
      syncL <= metaL;
      if (!clrN) begin
        holdE <= '0;
        holdL <= '0;
      end else begin
        holdE <= holdE | syncE;
        holdL <= holdL | syncL;
      end
    end
  end
endmodule

// File: rtl/lds_regs.sv
module lds_regs
  import lds_pkg::*;
#(
  parameter int LANES  = 30,
  parameter int ADDR_W = 5,
  parameter int DLY_W  = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  wrCmd_t                 cmd,
  input  logic [ADDR_W-1:0]      laneAddr,
  input  logic [1:0]             regSel,
  input  logic [DLY_W-1:0]       wrData,
  input  logic [LANES-1:0]       holdE,
  input  logic [LANES-1:0]       holdL,
  output logic [LANES*DLY_W-1:0] outDly,
  output logic [LANES*DLY_W-1:0] inDly,
  output logic [LANES*DLY_W-1:0] dpaDly,
  output logic [LANES-1:0]       laneOe,
  output logic [DLY_W-1:0]       rdValue,
  output logic                   rdEarly,
  output logic                   rdLate
);
  logic [LANES-1:0] laneHit;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [DLY_W-1:0] outQ, inQ, dpaQ;
    logic             laneWe;

    assign laneHit[i] = (laneAddr == ADDR_W'(i));
    assign laneWe     = cmd.allLanes || laneHit[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        outQ <= '0;
        inQ  <= '0;
        dpaQ <= '0;
      end else if (laneWe) begin
        if (cmd.wrOut) outQ <= wrData;
        if (cmd.wrIn)  inQ  <= wrData;
        if (cmd.wrDpa) dpaQ <= wrData;
      end
    end

    assign outDly[i*DLY_W +: DLY_W] = outQ;
    assign inDly[i*DLY_W +: DLY_W]  = inQ;
    assign dpaDly[i*DLY_W +: DLY_W] = dpaQ;
  end

  assign laneOe = laneHit;

  always_comb begin
    rdValue = '0;
    rdEarly = 1'b0;
    rdLate  = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (laneHit[i]) begin
        unique case (regSel)
          SEL_OUT: rdValue = outDly[i*DLY_W +: DLY_W];
          SEL_IN:  rdValue = inDly[i*DLY_W +: DLY_W];
          SEL_DPA: rdValue = dpaDly[i*DLY_W +: DLY_W];
          default: rdValue = '0;
        endcase
        rdEarly = holdE[i];
        rdLate  = holdL[i];
      end
    end
  end
endmodule

// File: rtl/lane_delay_store.sv
module lane_delay_store
  import lds_pkg::*;
#(
  parameter int LANES  = 30,
  parameter int ADDR_W = 5,
  parameter int DLY_W  = 6
) (
  input  logic                   mgmtClk,
  input  logic                   rst,
  input  logic                   flagClrN,
  input  logic                   loadStb,
  input  logic                   singleLane,
  input  logic [ADDR_W-1:0]      laneAddr,
  input  logic [1:0]             regSel,
  input  logic [DLY_W-1:0]       wrData,
  input  logic [LANES-1:0]       earlyRaw,
  input  logic [LANES-1:0]       lateRaw,
  output logic [LANES*DLY_W-1:0] outDly,
  output logic [LANES*DLY_W-1:0] inDly,
  output logic [LANES*DLY_W-1:0] dpaDly,
  output logic [LANES-1:0]       laneOe,
  output logic [DLY_W-1:0]       rdValue,
  output logic                   rdEarly,
  output logic                   rdLate
);
  wrCmd_t           cmd;
  logic [LANES-1:0] holdE, holdL;

  lds_ctrl #(.LANES(LANES), .ADDR_W(ADDR_W)) u_ctrl (
    .loadStb    (loadStb),
    .singleLane (singleLane),
    .laneAddr   (laneAddr),
    .regSel     (regSel),
    .cmd        (cmd)
  );

  lds_flags #(.LANES(LANES)) u_flags (
    .clk   (mgmtClk),
    .rst   (rst),
    .clrN  (flagClrN),
    .rawE  (earlyRaw),
    .rawL  (lateRaw),
    .holdE (holdE),
    .holdL (holdL)
  );

  lds_regs #(.LANES(LANES), .ADDR_W(ADDR_W), .DLY_W(DLY_W)) u_regs (
    .clk      (mgmtClk),
    .rst      (rst),
    .cmd      (cmd),
    .laneAddr (laneAddr),
    .regSel   (regSel),
    .wrData   (wrData),
    .holdE    (holdE),
    .holdL    (holdL),
    .outDly   (outDly),
    .inDly    (inDly),
    .dpaDly   (dpaDly),
    .laneOe   (laneOe),
    .rdValue  (rdValue),
    .rdEarly  (rdEarly),
    .rdLate   (rdLate)
  );
endmodule

// File: rtl/lane_delay_store_chk.sv
module lane_delay_store_chk #(
  parameter int LANES  = 30,
  parameter int ADDR_W = 5,
  parameter int DLY_W  = 6
) (
  input logic                   mgmtClk,
  input logic                   rst,
  input logic                   flagClrN,
  input logic                   loadStb,
  input logic                   singleLane,
  input logic [ADDR_W-1:0]      laneAddr,
  input logic [1:0]             regSel,
  input logic [DLY_W-1:0]       wrData,
  input logic [LANES*DLY_W-1:0] outDly,
  input logic [LANES*DLY_W-1:0] inDly,
  input logic [LANES*DLY_W-1:0] dpaDly,
  input logic [LANES-1:0]       laneOe,
  input logic [DLY_W-1:0]       rdValue,
  input logic                   rdEarly,
  input logic                   rdLate
);
  assert_quiet_no_load_R4: assert property (@(posedge mgmtClk) disable iff (rst)
    !loadStb |=> ($stable(outDly) && $stable(inDly) && $stable(dpaDly)));

  assert_reserved_sel_R5: assert property (@(posedge mgmtClk) disable iff (rst)
    (loadStb && regSel == 2'b11) |=> ($stable(outDly) && $stable(inDly) && $stable(dpaDly)));

  assert_bad_addr_R6: assert property (@(posedge mgmtClk) disable iff (rst)
    (loadStb && int'(laneAddr) >= LANES) |=> ($stable(outDly) && $stable(inDly) && $stable(dpaDly)));

  assert_broadcast_in_R3: assert property (@(posedge mgmtClk) disable iff (rst)
    (loadStb && !singleLane && regSel == 2'b01 && int'(laneAddr) < LANES)
      |=> (inDly == {LANES{$past(wrData)}}));

  assert_no_match_zero_R7: assert property (@(posedge mgmtClk) disable iff (rst)
    (int'(laneAddr) >= LANES) |-> (rdValue == '0 && !rdEarly && !rdLate));

  assert_oe_onehot_R8: assert property (@(posedge mgmtClk) disable iff (rst)
    $onehot0(laneOe) && ((int'(laneAddr) >= LANES) == (laneOe == '0)));

  assert_flag_clear_R10: assert property (@(posedge mgmtClk) disable iff (rst)
    !flagClrN |=> (!rdEarly && !rdLate));
endmodule

bind lane_delay_store lane_delay_store_chk #(
  .LANES(LANES), .ADDR_W(ADDR_W), .DLY_W(DLY_W)
) u_chk (.*);

// File: tb/lane_delay_store_test.sv
`timescale 1ns/1ps
module lane_delay_store_test;
  localparam int LANES  = 30;
  localparam int ADDR_W = 5;
  localparam int DLY_W  = 6;

  logic                   mgmtClk = 1'b0;
  logic                   rst = 1'b1;
  logic                   flagClrN = 1'b1;
  logic                   loadStb = 1'b0;
  logic                   singleLane = 1'b1;
  logic [ADDR_W-1:0]      laneAddr = '0;
  logic [1:0]             regSel = '0;
  logic [DLY_W-1:0]       wrData = '0;
  logic [LANES-1:0]       earlyRaw = '0;
  logic [LANES-1:0]       lateRaw = '0;
  logic [LANES*DLY_W-1:0] outDly, inDly, dpaDly;
  logic [LANES-1:0]       laneOe;
  logic [DLY_W-1:0]       rdValue;
  logic                   rdEarly, rdLate;

  always #2.5 mgmtClk = ~mgmtClk;

  lane_delay_store #(.LANES(LANES), .ADDR_W(ADDR_W), .DLY_W(DLY_W)) uut (.*);

  typedef struct {
    string            req;
    logic [DLY_W-1:0] val;
    logic             e;
    logic             l;
    logic [LANES-1:0] oe;
  } item_t;

  item_t            expQ[$];
  int               total = 0;
  int               bad = 0;
  logic [DLY_W-1:0] mOut[LANES];
  logic [DLY_W-1:0] mIn[LANES];
  logic [DLY_W-1:0] mDpa[LANES];

  // Monitor: compares readback against queued expectations
  initial begin
    forever begin
      @(negedge mgmtClk);
      if (expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        total++;
        if (rdValue !== it.val || rdEarly !== it.e || rdLate !== it.l || laneOe !== it.oe) begin
          bad++;
          $display("FAIL %s: got val=%h e=%b l=%b oe=%h exp val=%h e=%b l=%b oe=%h",
                   it.req, rdValue, rdEarly, rdLate, laneOe, it.val, it.e, it.l, it.oe);
        end
      end
    end
  end

  task automatic expectRead(input string req, input int lane, input logic [1:0] sel,
                            input logic e, input logic l);
    item_t it;
    laneAddr = ADDR_W'(lane);
    regSel   = sel;
    it.req = req;
    it.e   = e;
    it.l   = l;
    it.oe  = (lane < LANES) ? (LANES'(1) << lane) : '0;
    if (lane >= LANES || sel == 2'b11) it.val = '0;
    else if (sel == 2'b00) it.val = mOut[lane];
    else if (sel == 2'b01) it.val = mIn[lane];
    else it.val = mDpa[lane];
    expQ.push_back(it);
    @(negedge mgmtClk); #1;
  endtask

  task automatic doWrite(input logic single, input int lane, input logic [1:0] sel,
                         input logic [DLY_W-1:0] data, input logic stb);
    singleLane = single;
    laneAddr   = ADDR_W'(lane);
    regSel     = sel;
    wrData     = data;
    loadStb    = stb;
    @(negedge mgmtClk); #1;
    loadStb    = 1'b0;
    if (stb && lane < LANES && sel != 2'b11) begin
      for (int i = 0; i < LANES; i++) begin
        if (!single || i == lane) begin
          if (sel == 2'b00) mOut[i] = data;
          else if (sel == 2'b01) mIn[i] = data;
          else mDpa[i] = data;
        end
      end
    end
  endtask

  task automatic checkStore(input string req);
    logic [LANES*DLY_W-1:0] eo, ei, ed;
    for (int i = 0; i < LANES; i++) begin
      eo[i*DLY_W +: DLY_W] = mOut[i];
      ei[i*DLY_W +: DLY_W] = mIn[i];
      ed[i*DLY_W +: DLY_W] = mDpa[i];
    end
    total += 3;
    if (outDly !== eo) begin bad++; $display("FAIL %s outDly: got %h exp %h", req, outDly, eo); end
    if (inDly  !== ei) begin bad++; $display("FAIL %s inDly: got %h exp %h", req, inDly, ei); end
    if (dpaDly !== ed) begin bad++; $display("FAIL %s dpaDly: got %h exp %h", req, dpaDly, ed); end
  endtask

  task automatic finishRun();
    while (expQ.size() > 0) @(negedge mgmtClk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < LANES; i++) begin mOut[i] = '0; mIn[i] = '0; mDpa[i] = '0; end
    repeat (3) @(negedge mgmtClk);
    #1 rst = 1'b0;

    // R1: reset state
    checkStore("R1 reset");
    expectRead("R1 reset read out", 0, 2'b00, 1'b0, 1'b0);
    expectRead("R1 reset read dpa", 29, 2'b10, 1'b0, 1'b0);

    // R2: single-lane writes
    doWrite(1'b1, 5, 2'b00, 6'h2A, 1'b1);
    checkStore("R2 lane5 out");
    doWrite(1'b1, 29, 2'b10, 6'h3F, 1'b1);
    doWrite(1'b1, 0, 2'b01, 6'h11, 1'b1);
    checkStore("R2 lane29 dpa lane0 in");
    expectRead("R7 read lane5 out", 5, 2'b00, 1'b0, 1'b0);
    expectRead("R7 read lane29 dpa", 29, 2'b10, 1'b0, 1'b0);

    // R3: broadcast
    doWrite(1'b0, 12, 2'b01, 6'h15, 1'b1);
    checkStore("R3 broadcast in");
    expectRead("R3 read lane 17 in", 17, 2'b01, 1'b0, 1'b0);

    // R4: strobe low
    doWrite(1'b0, 3, 2'b00, 6'h07, 1'b0);
    checkStore("R4 strobe low");

    // R5: reserved selector
    doWrite(1'b0, 3, 2'b11, 6'h09, 1'b1);
    doWrite(1'b1, 5, 2'b11, 6'h09, 1'b1);
    checkStore("R5 reserved sel");
    expectRead("R7 reserved sel read", 5, 2'b11, 1'b0, 1'b0);

    // R6: out-of-range address
    doWrite(1'b1, 30, 2'b00, 6'h33, 1'b1);
    doWrite(1'b0, 31, 2'b10, 6'h21, 1'b1);
    checkStore("R6 bad address");
    expectRead("R8 addr30 no lane", 30, 2'b00, 1'b0, 1'b0);
    expectRead("R8 addr7 enable", 7, 2'b01, 1'b0, 1'b0);

    // R9: flag synchronisation depth and hold
    earlyRaw[3] = 1'b1;
    lateRaw[3]  = 1'b1;
    @(negedge mgmtClk); #1;
    expectRead("R9 flag not yet", 3, 2'b00, 1'b0, 1'b0);
    expectRead("R9 flag on 3rd edge", 3, 2'b00, 1'b1, 1'b1);
    earlyRaw[3] = 1'b0;
    lateRaw[3]  = 1'b0;
    repeat (4) @(negedge mgmtClk); #1;
    expectRead("R9 flag held", 3, 2'b00, 1'b1, 1'b1);
    expectRead("R10 neighbour lane clean", 4, 2'b00, 1'b0, 1'b0);

    // R10: clear
    flagClrN = 1'b0;
    @(negedge mgmtClk); #1;
    flagClrN = 1'b1;
    expectRead("R10 flags cleared", 3, 2'b00, 1'b0, 1'b0);

    // R1: reset again after data is present
    rst = 1'b1;
    @(negedge mgmtClk); #1;
    rst = 1'b0;
    for (int i = 0; i < LANES; i++) begin mOut[i] = '0; mIn[i] = '0; mDpa[i] = '0; end
    checkStore("R1 reset after writes");

    finishRun();
  end
endmodule